// File: doc/BRIEF.md
# LCD Seven-Segment Digit Driver with Code Hold

This block drives one digit of a directly driven liquid-crystal display. A 4-bit binary-coded-decimal value enters on `bcd_in`. While `load_en` is high the value passes straight through to the decoder and is also captured into a holding register. While `load_en` is low the decoder shows the held value, and the data input has no effect. The decoder converts digits 0 to 9 into seven segment lines. Codes 10 to 15 and an active `blank` input give an all-dark pattern.

Liquid crystals must never see a DC voltage. The block therefore generates the backplane square wave itself, using a clock divider. A polarity stage XORs every segment line with an effective phase. In LCD mode that phase is the backplane itself. A lit segment then always sits opposite the backplane and a dark segment always follows it. Outside LCD mode the `invert` input sets the polarity directly, which suits displays that need a fixed active level. The segment lines are registered and update on the same edge as the backplane, so the two never drift apart by a cycle.

Top module: `lcd_seg_driver`

## Requirements
- R1: A synchronous active-high `rst` drives `seg` to 7'h00 and `backplane` low and clears the held code to 0. After reset, with `load_en`, `blank`, `invert` and `lcd_mode` all low, the next edge shows digit 0 (7'h3F).
- R2: While `load_en` is high, the decoder uses `bcd_in` directly and the holding register captures `bcd_in` on every clock edge.
- R3: While `load_en` is low, `bcd_in` is ignored and the display keeps the last code captured while `load_en` was high.
- R4: Segment bit positions are `seg[0]`=a (top), then b, c, d, e, f clockwise, and `seg[6]`=g (middle). With polarity low, digits 0..9 give 7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F and 7'h6F.
- R5: Codes 10 through 15 give the all-dark pattern 7'h00 before polarity is applied.
- R6: `blank` high forces the pattern to 7'h00 before polarity is applied, whatever the code.
- R7: When the effective phase is high, all seven segment lines are the bitwise inverse of the polarity-low value. A blanked digit therefore reads 7'h7F.
- R8: With `lcd_mode` high the effective phase equals `backplane`, and `invert` is ignored. With `lcd_mode` low the effective phase equals `invert`.
- R9: `backplane` starts low after reset and toggles every HALF_PERIOD clock cycles; the first toggle comes HALF_PERIOD edges after reset is released.
- R10: A change on `bcd_in`, `load_en`, `blank`, `invert` or `lcd_mode` reaches `seg` exactly one clock edge later. `seg` is always computed from the same backplane value that `backplane` shows in that cycle, with no skew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 4 | Digit code |
| load_en | input | 1 | High: code passes through and is captured; low: code is held |
| blank | input | 1 | High: all segments dark before polarity |
| invert | input | 1 | Polarity when LCD mode is off |
| lcd_mode | input | 1 | High: polarity follows the backplane |
| seg | output | 7 | Segment lines, bit 0 = a through bit 6 = g |
| backplane | output | 1 | Backplane square wave |

## Verification
A held code corrupted while `load_en` is low shows up on `seg` one edge later as a wrong digit. The same corruption can stay hidden while `blank` is high or the code lies in the dark range, so the hold checks run with blanking off and on visible digits. A divider that counts wrong shows up as a `backplane` toggle at the wrong cycle. It can also show as a cycle in LCD mode where a lit segment equals the backplane level, and the per-cycle comparison against the bench model catches either within one clock.

// File: rtl/lcd_seg_pkg.sv
`timescale 1ns/1ps
package lcd_seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;
  localparam int DIGITS = 10;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  // bit 0 = a ... bit 6 = g
  function automatic seg_t digit_shape(input code_t c);
    seg_t s;
    case (c)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lcd_code_hold.sv
`timescale 1ns/1ps
module lcd_code_hold
  import lcd_seg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_en,
  input  code_t bcd_in,
  output code_t code_view
);
  code_t code_q;

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (load_en) code_q <= bcd_in;
  end

  // transparent path: open latch shows the live input
  assign code_view = load_en ? bcd_in : code_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(code_q)) else $error("held code moved"); // R3
endmodule

// File: rtl/lcd_bp_divider.sv
`timescale 1ns/1ps
module lcd_bp_divider #(
  parameter int HALF_PERIOD = 16
) (
  input  logic clk,
  input  logic rst,
  output logic bp_q,
  output logic bp_next
);
  localparam int CNT_W = (HALF_PERIOD > 2) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = (cnt_q == LAST);
  assign bp_next = wrap ? ~bp_q : bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bp_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      bp_q  <= bp_next;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST) else $error("divider count out of range"); // R9
  AST_BP_STEADY: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != LAST) |=> $stable(bp_q)) else $error("backplane toggled early"); // R9
  AST_BP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (bp_q != $past(bp_q))) else $error("backplane missed toggle"); // R9
endmodule

// File: rtl/lcd_seg_decode.sv
`timescale 1ns/1ps
module lcd_seg_decode
  import lcd_seg_pkg::*;
(
  input  code_t code,
  input  logic  blank,
  output seg_t  shape
);
  logic in_range;
  seg_t raw;

  assign in_range = (code < CODE_W'(DIGITS));
  assign raw      = digit_shape(code);
  assign shape    = (blank || !in_range) ? '0 : raw;
endmodule

// File: rtl/lcd_seg_outreg.sv
`timescale 1ns/1ps
module lcd_seg_outreg
  import lcd_seg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  seg_t shape,
  input  logic phase,
  output seg_t seg_q
);
  seg_t drive;

  for (genvar i = 0; i < SEG_N; i++) begin : g_pol
    assign drive[i] = shape[i] ^ phase;
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= '0;
    else     seg_q <= drive;
  end
endmodule

// File: rtl/lcd_seg_driver.sv
`timescale 1ns/1ps
module lcd_seg_driver
  import lcd_seg_pkg::*;
#(
  parameter int HALF_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] bcd_in,
  input  logic       load_en,
  input  logic       blank,
  input  logic       invert,
  input  logic       lcd_mode,
  output logic [6:0] seg,
  output logic       backplane
);
  code_t code_view;
  seg_t  shape;
  seg_t  seg_q;
  logic  bp_q, bp_next, phase;

  lcd_code_hold u_hold (
    .clk(clk), .rst(rst), .load_en(load_en), .bcd_in(bcd_in), .code_view(code_view)
  );

  lcd_bp_divider #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk(clk), .rst(rst), .bp_q(bp_q), .bp_next(bp_next)
  );

  lcd_seg_decode u_dec (
    .code(code_view), .blank(blank), .shape(shape)
  );

  // next backplane value keeps segments and backplane in the same cycle
  assign phase = lcd_mode ? bp_next : invert;

  lcd_seg_outreg u_out (
    .clk(clk), .rst(rst), .shape(shape), .phase(phase), .seg_q(seg_q)
  );

  assign seg       = seg_q;
  assign backplane = bp_q;

  AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (blank && !lcd_mode) |=> (seg == {7{$past(invert)}})) else $error("blank level wrong"); // R6
  AST_DARK_CODES: assert property (@(posedge clk) disable iff (rst)
    (load_en && bcd_in > 4'd9 && !lcd_mode) |=> (seg == {7{$past(invert)}})) else $error("code above 9 lit"); // R5
  AST_LCD_NO_SKEW: assert property (@(posedge clk) disable iff (rst)
    (blank && lcd_mode) |=> (seg == {7{backplane}})) else $error("segment skewed from backplane"); // R10
  AST_LCD_LIT_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    (!blank && lcd_mode && load_en && bcd_in == 4'd8) |=> (seg == ~{7{backplane}})) else $error("lit segment not opposite"); // R8
endmodule

// File: tb/tb_lcd_seg_driver.sv
`timescale 1ns/1ps
module tb_lcd_seg_driver;
  localparam int H = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] bcd_in = '0;
  logic       load_en = 1'b0, blank = 1'b0, invert = 1'b0, lcd_mode = 1'b0;
  logic [6:0] seg;
  logic       backplane;

  int checks = 0, fails = 0;
  bit done = 0, mon_en = 0;

  lcd_seg_driver #(.HALF_PERIOD(H)) dut (
    .clk(clk), .rst(rst), .bcd_in(bcd_in), .load_en(load_en), .blank(blank),
    .invert(invert), .lcd_mode(lcd_mode), .seg(seg), .backplane(backplane)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] ref_shape(input logic [3:0] c);
    case (c)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B; 4'd3: return 7'h4F;
      4'd4: return 7'h66; 4'd5: return 7'h6D; 4'd6: return 7'h7D; 4'd7: return 7'h07;
      4'd8: return 7'h7F; 4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] ref_seg(input logic [3:0] c, input logic b, input logic ph);
    return (b ? 7'h00 : ref_shape(c)) ^ {7{ph}};
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // requirement-level model
  logic [3:0] m_code;
  int         m_cnt;
  logic       m_bp;
  logic [6:0] m_seg;
  always @(posedge clk) begin
    logic [3:0] view;
    logic       bpn;
    if (rst) begin
      m_code = 0; m_cnt = 0; m_bp = 0; m_seg = 0;
    end else begin
      view = load_en ? bcd_in : m_code;
      if (load_en) m_code = bcd_in;
      bpn = (m_cnt == H-1) ? ~m_bp : m_bp;
      m_cnt = (m_cnt == H-1) ? 0 : m_cnt + 1;
      m_bp = bpn;
      m_seg = ref_seg(view, blank, lcd_mode ? bpn : invert);
    end
  end

  always @(negedge clk) begin
    if (mon_en && !done) begin
      check("R10 seg vs model", seg, m_seg);
      check("R9 backplane vs model", {6'b0, backplane}, {6'b0, m_bp});
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    int last_t, t;
    logic prev_bp;
    void'($urandom(32'd20240611));
    step(); step();
    check("R1 seg in reset", seg, 7'h00);
    check("R1 backplane in reset", {6'b0, backplane}, 7'h00);
    rst = 1'b0;
    mon_en = 1;
    step();
    check("R1 held code 0 after reset", seg, 7'h3F);

    // exhaustive table, polarity from invert
    for (int c = 0; c < 16; c++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++) begin
          bcd_in = 4'(c); blank = b[0]; invert = p[0]; load_en = 1'b1; lcd_mode = 1'b0;
          step();
          if (b) check("R6 blank", seg, ref_seg(4'(c), 1'b1, p[0]));
          else if (c > 9) check("R5 dark code", seg, ref_seg(4'(c), 1'b0, p[0]));
          else if (p) check("R7 inverted digit", seg, ref_seg(4'(c), 1'b0, 1'b1));
          else check("R4 digit decode", seg, ref_shape(4'(c)));
        end

    // transparency and one-edge latency
    blank = 0; invert = 0; bcd_in = 4'd2; load_en = 1;
    step();
    bcd_in = 4'd7;
    check("R10 no change before edge", seg, 7'h5B);
    step();
    check("R2 pass-through", seg, 7'h07);

    // hold
    bcd_in = 4'd5; step();
    load_en = 0;
    for (int i = 0; i < 8; i++) begin
      bcd_in = 4'($urandom_range(0, 15));
      step();
      check("R3 held digit", seg, 7'h6D);
    end
    invert = 1; step();
    check("R3 held digit inverted", seg, ~7'h6D);

    // LCD mode: lit opposite backplane, invert ignored, period
    load_en = 1; bcd_in = 4'd8; lcd_mode = 1; invert = 0;
    step();
    prev_bp = backplane; last_t = -1; t = 0;
    for (int i = 0; i < 6*H; i++) begin
      invert = 1'($urandom_range(0, 1));
      step(); t++;
      check("R8 lit opposite backplane", seg, ~{7{backplane}});
      if (backplane != prev_bp) begin
        if (last_t >= 0) check("R9 half period", 7'(t - last_t), 7'(H));
        last_t = t;
      end
      prev_bp = backplane;
    end
    blank = 1; step();
    check("R8 blanked follows backplane", seg, {7{backplane}});
    blank = 0;

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bcd_in   = 4'($urandom_range(0, 15));
      load_en  = ($urandom_range(0, 3) != 0);
      blank    = ($urandom_range(0, 5) == 0);
      invert   = 1'($urandom_range(0, 1));
      lcd_mode = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 199) == 0) rst = 1; else rst = 0;
      step();
    end
    rst = 0;

    // reset mid-run: backplane restarts low, first toggle after H edges
    rst = 1; lcd_mode = 1; blank = 1; load_en = 0; step();
    rst = 0;
    for (int i = 1; i <= H; i++) begin
      step();
      check("R9 toggle timing after reset", {6'b0, backplane}, (i == H) ? 7'h01 : 7'h00);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule